// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block holds the sixteen general registers that a processor core sees, and keeps private copies of some of them for each privilege mode. A 5-bit mode code selects one of several banks through a fixed table. When the core requests a mode change, the block saves the outgoing bank's shadowed registers into storage and loads the incoming bank's copies into the live set. All of this happens on one clock edge, so the new bank is visible to any read issued in the following cycle.

Two registered read ports and one write port serve the datapath. A cross-mode port lets a debugger or exception handler read or write any mode's copy of a register without changing mode. It goes to the live set when the requested mode maps to the current bank, and to the stored copy otherwise. Entry 15 is the program counter; every write to it is forced to word alignment. R0 to R7 and R15 are never shadowed.

Top module: `banked_regfile`

## Requirements
- R1: Reset (synchronous, active high) selects mode code 19 (supervisor) and clears every live register, every stored copy and the three read outputs.
- R2: Both read ports return the live register addressed in the previous cycle. A write in that same cycle is not forwarded and becomes visible one cycle later. The two ports read independently.
- R3: A write to entry 15 through the write port or the cross-mode port stores the data with bits 1:0 cleared.
- R4: Mode codes map to banks as follows: 0, 16 and 31 to user; 1 and 17 to fast interrupt; 2 and 18 to interrupt; 3 and 19 to supervisor; 23 to abort; 27 to undefined; all other codes to a dummy bank.
- R5: A switch between two of the user, interrupt, supervisor, abort and undefined banks saves and restores R13 and R14 only, and leaves R8 to R12 unchanged.
- R6: Entering the fast-interrupt bank from a non-fast bank saves the live R8 to R12 as the user copy and then loads the fast-interrupt R8 to R14. Leaving it for one of the R5 banks restores R8 to R12 from the user copy and loads that bank's R13 and R14.
- R7: Entering the dummy bank sets R8 to R14 to zero and saves nothing into the dummy bank. Leaving the dummy bank for one of the R5 banks loads only R13 and R14, so R8 to R12 stay zero.
- R8: A switch between two codes of the same bank updates the current mode and leaves R8 to R14 unchanged.
- R9: The cross-mode port reads and writes the live register when the requested mode maps to the current bank. For another bank it uses that bank's stored copy of the register. In the dummy bank R8 to R14 read as zero and writes to them are dropped. Its read data is registered one cycle.
- R10: Through the cross-mode port, a register that the target bank does not shadow goes to the live set. The exception is R8 to R12 of an R5 bank while the current bank is fast interrupt, which goes to the stored user copy.
- R11: Every write, on either port, in a cycle with the switch request high is dropped. When both ports write the same live register in one cycle, the write port wins.
- R12: After a switch request the current-mode output equals the requested code on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 4 | Read port A register index |
| rd_a_data | output | DW | Read port A data, one cycle after address |
| rd_b_addr | input | 4 | Read port B register index |
| rd_b_data | output | DW | Read port B data, one cycle after address |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port register index |
| wr_data | input | DW | Write port data |
| sw_req | input | 1 | Mode switch request |
| sw_mode | input | 5 | Requested mode code |
| cur_mode | output | 5 | Current mode code |
| xa_we | input | 1 | Cross-mode port write enable |
| xa_mode | input | 5 | Cross-mode port target mode |
| xa_addr | input | 4 | Cross-mode port register index |
| xa_wdata | input | DW | Cross-mode port write data |
| xa_rdata | output | DW | Cross-mode port read data, one cycle after address |

## Verification
The bench walks a mode sequence that visits every bank kind and reads back R8, R13 and R14 after each switch. A design that forgot the user copy of R8 to R12 would return fast-interrupt values after leaving that mode. A design that restored R8 to R12 when leaving the dummy bank would show stale values where zeros are expected. It also checks that a switch between codes 16, 0 and 31 leaves R8 to R14 intact, and a design that saved and restored anyway would still pass that check. The cross-mode port is driven at live, stored, unshadowed, user-copy and dummy targets, so a wrong target choice returns the other copy's value. Writes that collide with a switch, or with each other, are checked to be dropped or ordered, and PC writes on both ports are checked to lose their two low bits.

// File: rtl/bkrf_pkg.sv
package bkrf_pkg;
  localparam int NREG    = 16;
  localparam int AW      = 4;
  localparam int MW      = 5;
  localparam int HI_BASE = 8;          // first register any bank can shadow
  localparam int NHI     = 7;          // R8..R14
  localparam int NLO     = 5;          // R8..R12, fast-interrupt only
  localparam int NPAIR   = 5;          // banks shadowing R13/R14 only
  localparam int SP_IDX  = 13;
  localparam int LR_IDX  = 14;
  localparam int PC_IDX  = 15;
  localparam logic [MW-1:0] RESET_MODE = 5'd19;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
    BK_ABT = 3'd4, BK_UND = 3'd5, BK_DUM = 3'd6
  } bank_e;

  typedef enum logic [2:0] {
    TG_LIVE, TG_PAIR, TG_FIQ, TG_USRLO, TG_NULL
  } tgt_e;

  function automatic bank_e bank_of(input logic [MW-1:0] m);
    case (m)
      5'd0, 5'd16, 5'd31: bank_of = BK_USR;
      5'd1, 5'd17:        bank_of = BK_FIQ;
      5'd2, 5'd18:        bank_of = BK_IRQ;
      5'd3, 5'd19:        bank_of = BK_SVC;
      5'd23:              bank_of = BK_ABT;
      5'd27:              bank_of = BK_UND;
      default:            bank_of = BK_DUM;
    endcase
  endfunction

  function automatic logic is_pair(input bank_e b);
    is_pair = (b == BK_USR) || (b == BK_IRQ) || (b == BK_SVC) ||
              (b == BK_ABT) || (b == BK_UND);
  endfunction

  function automatic logic [2:0] pair_slot(input bank_e b);
    case (b)
      BK_IRQ:  pair_slot = 3'd1;
      BK_SVC:  pair_slot = 3'd2;
      BK_ABT:  pair_slot = 3'd3;
      BK_UND:  pair_slot = 3'd4;
      default: pair_slot = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bkrf_live.sv
module bkrf_live
  import bkrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wa_en,
  input  logic [AW-1:0]             wa_addr,
  input  logic [DW-1:0]             wa_data,
  input  logic                      wb_en,
  input  logic [AW-1:0]             wb_addr,
  input  logic [DW-1:0]             wb_data,
  input  logic [NHI-1:0]            ld_mask,
  input  logic [NHI-1:0][DW-1:0]    ld_val,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  localparam logic [DW-1:0] PC_MASK = ~{{(DW-2){1'b0}}, 2'b11};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(i);
    localparam bit IS_PC = (i == PC_IDX);
    logic [DW-1:0] wa_v, wb_v;
    assign wa_v = IS_PC ? (wa_data & PC_MASK) : wa_data;
    assign wb_v = IS_PC ? (wb_data & PC_MASK) : wb_data;

    if (i >= HI_BASE && i < HI_BASE + NHI) begin : g_hi
      always_ff @(posedge clk) begin
        if (rst)                              regs_o[i] <= '0;
        else if (ld_mask[i-HI_BASE])          regs_o[i] <= ld_val[i-HI_BASE];
        else if (wa_en && wa_addr == IDX)     regs_o[i] <= wa_v;
        else if (wb_en && wb_addr == IDX)     regs_o[i] <= wb_v;
      end
    end else begin : g_flat
      always_ff @(posedge clk) begin
        if (rst)                              regs_o[i] <= '0;
        else if (wa_en && wa_addr == IDX)     regs_o[i] <= wa_v;
        else if (wb_en && wb_addr == IDX)     regs_o[i] <= wb_v;
      end
    end
  end
endmodule

// File: rtl/bkrf_store.sv
module bkrf_store
  import bkrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NHI-1:0][DW-1:0]    live_hi,
  input  logic                      save_pair_en,
  input  logic [2:0]                save_pair_slot,
  input  logic                      save_fiq_en,
  input  logic                      save_usr_en,
  input  logic                      xw_pair_en,
  input  logic [2:0]                xw_pair_slot,
  input  logic                      xw_pair_lr,
  input  logic                      xw_fiq_en,
  input  logic                      xw_usr_en,
  input  logic [2:0]                xw_idx,
  input  logic [DW-1:0]             xw_data,
  output logic [NPAIR-1:0][DW-1:0]  pair_sp,
  output logic [NPAIR-1:0][DW-1:0]  pair_lr,
  output logic [NHI-1:0][DW-1:0]    fiq_hi,
  output logic [NLO-1:0][DW-1:0]    usr_lo
);
  localparam int SP_OFS = SP_IDX - HI_BASE;
  localparam int LR_OFS = LR_IDX - HI_BASE;

  for (genvar s = 0; s < NPAIR; s++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        pair_sp[s] <= '0;
        pair_lr[s] <= '0;
      end else if (save_pair_en && save_pair_slot == 3'(s)) begin
        pair_sp[s] <= live_hi[SP_OFS];
        pair_lr[s] <= live_hi[LR_OFS];
      end else if (xw_pair_en && xw_pair_slot == 3'(s)) begin
        if (xw_pair_lr) pair_lr[s] <= xw_data;
        else            pair_sp[s] <= xw_data;
      end
    end
  end

  for (genvar k = 0; k < NHI; k++) begin : g_fiq
    always_ff @(posedge clk) begin
      if (rst)                                 fiq_hi[k] <= '0;
      else if (save_fiq_en)                    fiq_hi[k] <= live_hi[k];
      else if (xw_fiq_en && xw_idx == 3'(k))   fiq_hi[k] <= xw_data;
    end
  end

  for (genvar k = 0; k < NLO; k++) begin : g_usr
    always_ff @(posedge clk) begin
      if (rst)                                 usr_lo[k] <= '0;
      else if (save_usr_en)                    usr_lo[k] <= live_hi[k];
      else if (xw_usr_en && xw_idx == 3'(k))   usr_lo[k] <= xw_data;
    end
  end
endmodule

// File: rtl/bkrf_switch.sv
module bkrf_switch
  import bkrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      sw_req,
  input  bank_e                     cur_bank,
  input  bank_e                     new_bank,
  input  logic [NPAIR-1:0][DW-1:0]  pair_sp,
  input  logic [NPAIR-1:0][DW-1:0]  pair_lr,
  input  logic [NHI-1:0][DW-1:0]    fiq_hi,
  input  logic [NLO-1:0][DW-1:0]    usr_lo,
  output logic [NHI-1:0]            ld_mask,
  output logic [NHI-1:0][DW-1:0]    ld_val,
  output logic                      save_pair_en,
  output logic [2:0]                save_pair_slot,
  output logic                      save_fiq_en,
  output logic                      save_usr_en
);
  localparam int SP_OFS = SP_IDX - HI_BASE;
  localparam int LR_OFS = LR_IDX - HI_BASE;

  logic do_swap;
  assign do_swap        = sw_req && (cur_bank != new_bank);
  assign save_pair_en   = do_swap && is_pair(cur_bank);
  assign save_pair_slot = pair_slot(cur_bank);
  assign save_usr_en    = do_swap && is_pair(cur_bank) && (new_bank == BK_FIQ);
  assign save_fiq_en    = do_swap && (cur_bank == BK_FIQ);

  always_comb begin
    ld_mask = '0;
    ld_val  = '0;
    if (do_swap) begin
      if (new_bank == BK_FIQ) begin
        ld_mask = '1;
        ld_val  = fiq_hi;
      end else if (new_bank == BK_DUM) begin
        ld_mask = '1;
      end else begin
        ld_mask[SP_OFS] = 1'b1;
        ld_mask[LR_OFS] = 1'b1;
        ld_val[SP_OFS]  = pair_sp[pair_slot(new_bank)];
        ld_val[LR_OFS]  = pair_lr[pair_slot(new_bank)];
        if (cur_bank == BK_FIQ) begin
          for (int k = 0; k < NLO; k++) begin
            ld_mask[k] = 1'b1;
            ld_val[k]  = usr_lo[k];
          end
        end
      end
    end
  end
endmodule

// File: rtl/bkrf_xsel.sv
module bkrf_xsel
  import bkrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [MW-1:0]             xa_mode,
  input  logic [AW-1:0]             xa_addr,
  input  logic                      xa_we,
  input  bank_e                     cur_bank,
  input  logic [NREG-1:0][DW-1:0]   live,
  input  logic [NPAIR-1:0][DW-1:0]  pair_sp,
  input  logic [NPAIR-1:0][DW-1:0]  pair_lr,
  input  logic [NHI-1:0][DW-1:0]    fiq_hi,
  input  logic [NLO-1:0][DW-1:0]    usr_lo,
  output logic [DW-1:0]             rdata,
  output logic                      we_live,
  output logic                      we_pair,
  output logic                      we_fiq,
  output logic                      we_usr,
  output logic [2:0]                slot,
  output logic                      is_lr,
  output logic [2:0]                idx
);
  bank_e tb;
  tgt_e  tgt;
  logic  in_hi, in_lo, in_pair;

  assign tb      = bank_of(xa_mode);
  assign in_hi   = (xa_addr >= AW'(HI_BASE)) && (xa_addr < AW'(HI_BASE + NHI));
  assign in_lo   = (xa_addr >= AW'(HI_BASE)) && (xa_addr < AW'(HI_BASE + NLO));
  assign in_pair = (xa_addr == AW'(SP_IDX)) || (xa_addr == AW'(LR_IDX));
  assign slot    = pair_slot(tb);
  assign is_lr   = (xa_addr == AW'(LR_IDX));
  assign idx     = 3'(xa_addr - AW'(HI_BASE));

  always_comb begin
    tgt = TG_LIVE;
    if (tb != cur_bank) begin
      if (tb == BK_DUM)                         tgt = in_hi ? TG_NULL : TG_LIVE;
      else if (tb == BK_FIQ)                    tgt = in_hi ? TG_FIQ  : TG_LIVE;
      else if (in_pair)                         tgt = TG_PAIR;
      else if (in_lo && cur_bank == BK_FIQ)     tgt = TG_USRLO;
    end
  end

  always_comb begin
    case (tgt)
      TG_PAIR:  rdata = is_lr ? pair_lr[slot] : pair_sp[slot];
      TG_FIQ:   rdata = fiq_hi[idx];
      TG_USRLO: rdata = usr_lo[idx];
      TG_NULL:  rdata = '0;
      default:  rdata = live[xa_addr];
    endcase
  end

  assign we_live = xa_we && (tgt == TG_LIVE);
  assign we_pair = xa_we && (tgt == TG_PAIR);
  assign we_fiq  = xa_we && (tgt == TG_FIQ);
  assign we_usr  = xa_we && (tgt == TG_USRLO);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bkrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     rd_a_addr,
  output logic [DW-1:0]  rd_a_data,
  input  logic [3:0]     rd_b_addr,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [3:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           sw_req,
  input  logic [4:0]     sw_mode,
  output logic [4:0]     cur_mode,
  input  logic           xa_we,
  input  logic [4:0]     xa_mode,
  input  logic [3:0]     xa_addr,
  input  logic [DW-1:0]  xa_wdata,
  output logic [DW-1:0]  xa_rdata
);
  logic [NREG-1:0][DW-1:0]  live_flat;
  logic [NPAIR-1:0][DW-1:0] pair_sp, pair_lr;
  logic [NHI-1:0][DW-1:0]   fiq_hi;
  logic [NLO-1:0][DW-1:0]   usr_lo;
  logic [NHI-1:0]           ld_mask;
  logic [NHI-1:0][DW-1:0]   ld_val;
  logic                     save_pair_en, save_fiq_en, save_usr_en;
  logic [2:0]               save_pair_slot;
  logic                     xs_live, xs_pair, xs_fiq, xs_usr, xs_lr;
  logic [2:0]               xs_slot, xs_idx;
  logic [DW-1:0]            xs_rdata;
  logic                     wr_ok, xw_ok;
  bank_e                    cur_bank, new_bank;

  assign cur_bank = bank_of(cur_mode);
  assign new_bank = bank_of(sw_mode);
  assign wr_ok    = wr_en && !sw_req;
  assign xw_ok    = xa_we && !sw_req;

  always_ff @(posedge clk) begin
    if (rst)         cur_mode <= RESET_MODE;
    else if (sw_req) cur_mode <= sw_mode;
  end

  bkrf_switch #(.DW(DW)) u_switch (
    .sw_req(sw_req), .cur_bank(cur_bank), .new_bank(new_bank),
    .pair_sp(pair_sp), .pair_lr(pair_lr), .fiq_hi(fiq_hi), .usr_lo(usr_lo),
    .ld_mask(ld_mask), .ld_val(ld_val),
    .save_pair_en(save_pair_en), .save_pair_slot(save_pair_slot),
    .save_fiq_en(save_fiq_en), .save_usr_en(save_usr_en)
  );

  bkrf_xsel #(.DW(DW)) u_xsel (
    .xa_mode(xa_mode), .xa_addr(xa_addr), .xa_we(xw_ok), .cur_bank(cur_bank),
    .live(live_flat), .pair_sp(pair_sp), .pair_lr(pair_lr),
    .fiq_hi(fiq_hi), .usr_lo(usr_lo), .rdata(xs_rdata),
    .we_live(xs_live), .we_pair(xs_pair), .we_fiq(xs_fiq), .we_usr(xs_usr),
    .slot(xs_slot), .is_lr(xs_lr), .idx(xs_idx)
  );

  bkrf_live #(.DW(DW)) u_live (
    .clk(clk), .rst(rst),
    .wa_en(wr_ok), .wa_addr(wr_addr), .wa_data(wr_data),
    .wb_en(xs_live), .wb_addr(xa_addr), .wb_data(xa_wdata),
    .ld_mask(ld_mask), .ld_val(ld_val), .regs_o(live_flat)
  );

  bkrf_store #(.DW(DW)) u_store (
    .clk(clk), .rst(rst), .live_hi(live_flat[HI_BASE +: NHI]),
    .save_pair_en(save_pair_en), .save_pair_slot(save_pair_slot),
    .save_fiq_en(save_fiq_en), .save_usr_en(save_usr_en),
    .xw_pair_en(xs_pair), .xw_pair_slot(xs_slot), .xw_pair_lr(xs_lr),
    .xw_fiq_en(xs_fiq), .xw_usr_en(xs_usr), .xw_idx(xs_idx), .xw_data(xa_wdata),
    .pair_sp(pair_sp), .pair_lr(pair_lr), .fiq_hi(fiq_hi), .usr_lo(usr_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
      xa_rdata  <= '0;
    end else begin
      rd_a_data <= live_flat[rd_a_addr];
      rd_b_data <= live_flat[rd_b_addr];
      xa_rdata  <= xs_rdata;
    end
  end
endmodule

// File: rtl/bkrf_checker.sv
module bkrf_checker
  import bkrf_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sw_req,
  input logic [4:0]               sw_mode,
  input logic [4:0]               cur_mode,
  input logic [3:0]               rd_a_addr,
  input logic [DW-1:0]            rd_a_data,
  input logic [NREG-1:0][DW-1:0]  live_flat
);
  p_reset_mode_r1: assert property (@(posedge clk) rst |=> cur_mode == RESET_MODE);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rd_a_data == $past(live_flat[rd_a_addr]));

  p_pc_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    live_flat[PC_IDX][1:0] == 2'b00);

  p_dummy_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_req && bank_of(sw_mode) == BK_DUM) |=> live_flat[HI_BASE +: NHI] == '0);

  p_same_bank_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_req && bank_of(sw_mode) == bank_of(cur_mode)) |=>
      live_flat[HI_BASE +: NHI] == $past(live_flat[HI_BASE +: NHI]));

  p_switch_drops_write_r11: assert property (@(posedge clk) disable iff (rst)
    sw_req |=> (live_flat[HI_BASE-1:0] == $past(live_flat[HI_BASE-1:0])) &&
               (live_flat[PC_IDX] == $past(live_flat[PC_IDX])));

  p_mode_tracks_r12: assert property (@(posedge clk) disable iff (rst)
    sw_req |=> cur_mode == $past(sw_mode));
endmodule

bind banked_regfile bkrf_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sw_req(sw_req), .sw_mode(sw_mode),
  .cur_mode(cur_mode), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .live_flat(live_flat)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int DW = 32;
  localparam int NV = 57;
  localparam logic [2:0] OP_WR = 3'd1, OP_SW = 3'd2, OP_RD = 3'd3,
                         OP_XW = 3'd4, OP_XR = 3'd5;

  // row: op[47:45] mode[44:40] addr[39:36] data/expect[35:4] requirement[3:0]
  localparam logic [47:0] VEC [NV] = '{
    {OP_WR, 5'd0,  4'd13, 32'h5555_0013, 4'd5},  // R5 svc sp
    {OP_WR, 5'd0,  4'd14, 32'h5555_0014, 4'd5},  // R5 svc lr
    {OP_WR, 5'd0,  4'd8,  32'h0000_0008, 4'd5},  // R5
    {OP_WR, 5'd0,  4'd0,  32'h0000_00A0, 4'd5},  // R5
    {OP_SW, 5'd18, 4'd0,  32'h0,         4'd5},  // R5 to interrupt
    {OP_RD, 5'd0,  4'd13, 32'h0,         4'd5},  // R5
    {OP_RD, 5'd0,  4'd8,  32'h0000_0008, 4'd5},  // R5 R8 kept
    {OP_WR, 5'd0,  4'd13, 32'h0000_1113, 4'd5},  // R5
    {OP_SW, 5'd19, 4'd0,  32'h0,         4'd5},  // R5 back to supervisor
    {OP_RD, 5'd0,  4'd13, 32'h5555_0013, 4'd5},  // R5
    {OP_RD, 5'd0,  4'd14, 32'h5555_0014, 4'd5},  // R5
    {OP_SW, 5'd17, 4'd0,  32'h0,         4'd6},  // R6 enter fast
    {OP_RD, 5'd0,  4'd8,  32'h0,         4'd6},  // R6
    {OP_RD, 5'd0,  4'd13, 32'h0,         4'd6},  // R6
    {OP_WR, 5'd0,  4'd8,  32'h0000_00F8, 4'd6},  // R6
    {OP_WR, 5'd0,  4'd13, 32'h0000_0F13, 4'd6},  // R6
    {OP_SW, 5'd0,  4'd0,  32'h0,         4'd6},  // R6 leave fast
    {OP_RD, 5'd0,  4'd8,  32'h0000_0008, 4'd6},  // R6 user copy back
    {OP_RD, 5'd0,  4'd13, 32'h0,         4'd6},  // R6
    {OP_SW, 5'd1,  4'd0,  32'h0,         4'd6},  // R6 enter fast again
    {OP_RD, 5'd0,  4'd8,  32'h0000_00F8, 4'd6},  // R6
    {OP_RD, 5'd0,  4'd13, 32'h0000_0F13, 4'd6},  // R6
    {OP_SW, 5'd16, 4'd0,  32'h0,         4'd4},  // R4 code 16 is user
    {OP_RD, 5'd0,  4'd8,  32'h0000_0008, 4'd4},  // R4
    {OP_WR, 5'd0,  4'd13, 32'h0000_0D0D, 4'd8},  // R8
    {OP_SW, 5'd31, 4'd0,  32'h0,         4'd8},  // R8 same bank
    {OP_RD, 5'd0,  4'd13, 32'h0000_0D0D, 4'd8},  // R8
    {OP_RD, 5'd0,  4'd8,  32'h0000_0008, 4'd8},  // R8
    {OP_XR, 5'd19, 4'd13, 32'h5555_0013, 4'd9},  // R9 stored svc
    {OP_XR, 5'd17, 4'd8,  32'h0000_00F8, 4'd9},  // R9 stored fast
    {OP_XR, 5'd0,  4'd13, 32'h0000_0D0D, 4'd9},  // R9 current bank live
    {OP_XR, 5'd18, 4'd13, 32'h0000_1113, 4'd9},  // R9 stored irq
    {OP_XR, 5'd18, 4'd0,  32'h0000_00A0, 4'd10}, // R10 unshadowed
    {OP_XR, 5'd18, 4'd8,  32'h0000_0008, 4'd10}, // R10
    {OP_XW, 5'd23, 4'd14, 32'h0000_AB14, 4'd9},  // R9 write abort copy
    {OP_SW, 5'd23, 4'd0,  32'h0,         4'd4},  // R4 abort
    {OP_RD, 5'd0,  4'd14, 32'h0000_AB14, 4'd9},  // R9
    {OP_RD, 5'd0,  4'd13, 32'h0,         4'd4},  // R4
    {OP_SW, 5'd5,  4'd0,  32'h0,         4'd7},  // R7 dummy
    {OP_RD, 5'd0,  4'd13, 32'h0,         4'd7},  // R7
    {OP_RD, 5'd0,  4'd8,  32'h0,         4'd7},  // R7
    {OP_SW, 5'd19, 4'd0,  32'h0,         4'd7},  // R7 leave dummy
    {OP_RD, 5'd0,  4'd13, 32'h5555_0013, 4'd7},  // R7
    {OP_RD, 5'd0,  4'd8,  32'h0,         4'd7},  // R7 R8 stays zero
    {OP_WR, 5'd0,  4'd15, 32'h0000_1007, 4'd3},  // R3
    {OP_RD, 5'd0,  4'd15, 32'h0000_1004, 4'd3},  // R3
    {OP_XW, 5'd19, 4'd15, 32'h0000_0203, 4'd3},  // R3 cross port
    {OP_RD, 5'd0,  4'd15, 32'h0000_0200, 4'd3},  // R3
    {OP_SW, 5'd17, 4'd0,  32'h0,         4'd10}, // R10 into fast
    {OP_XW, 5'd0,  4'd10, 32'h0000_010A, 4'd10}, // R10 user copy
    {OP_XR, 5'd0,  4'd10, 32'h0000_010A, 4'd10}, // R10
    {OP_RD, 5'd0,  4'd10, 32'h0,         4'd10}, // R10 live untouched
    {OP_SW, 5'd0,  4'd0,  32'h0,         4'd6},  // R6
    {OP_RD, 5'd0,  4'd10, 32'h0000_010A, 4'd10}, // R10
    {OP_XW, 5'd5,  4'd13, 32'h0000_DEAD, 4'd7},  // R7 dropped
    {OP_XR, 5'd5,  4'd13, 32'h0,         4'd7},  // R7
    {OP_XR, 5'd1,  4'd13, 32'h0000_0F13, 4'd9}   // R9
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    rd_a_addr, rd_b_addr, wr_addr, xa_addr;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data, xa_wdata, xa_rdata;
  logic          wr_en, sw_req, xa_we;
  logic [4:0]    sw_mode, cur_mode, xa_mode;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  banked_regfile #(.DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_req(sw_req), .sw_mode(sw_mode), .cur_mode(cur_mode),
    .xa_we(xa_we), .xa_mode(xa_mode), .xa_addr(xa_addr),
    .xa_wdata(xa_wdata), .xa_rdata(xa_rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_sw(input logic [4:0] m);
    sw_req = 1'b1; sw_mode = m;
    @(negedge clk);
    sw_req = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [DW-1:0] e, input string req);
    rd_a_addr = a;
    @(negedge clk);
    check(req, rd_a_data, e);
  endtask

  task automatic do_xw(input logic [4:0] m, input logic [3:0] a, input logic [DW-1:0] d);
    xa_we = 1'b1; xa_mode = m; xa_addr = a; xa_wdata = d;
    @(negedge clk);
    xa_we = 1'b0;
  endtask

  task automatic do_xr(input logic [4:0] m, input logic [3:0] a, input logic [DW-1:0] e, input string req);
    xa_mode = m; xa_addr = a;
    @(negedge clk);
    check(req, xa_rdata, e);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; sw_req = 1'b0; xa_we = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    sw_mode = '0; xa_mode = '0; xa_addr = '0; xa_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 mode", 32'(cur_mode), 32'd19);
    check("R1 rd_a", rd_a_data, '0);
    check("R1 xa", xa_rdata, '0);
    do_rd(4'd15, '0, "R1 pc");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[i][3:0], i);
      case (VEC[i][47:45])
        OP_WR: do_wr(VEC[i][39:36], VEC[i][35:4]);
        OP_SW: begin
          do_sw(VEC[i][44:40]);
          check(tag, 32'(cur_mode), 32'(VEC[i][44:40]));  // R12
        end
        OP_RD: do_rd(VEC[i][39:36], VEC[i][35:4], tag);
        OP_XW: do_xw(VEC[i][44:40], VEC[i][39:36], VEC[i][35:4]);
        OP_XR: do_xr(VEC[i][44:40], VEC[i][39:36], VEC[i][35:4], tag);
        default: ;
      endcase
    end

    // R11: writes in a switch cycle are dropped (user mode now)
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 32'h77;
    xa_we = 1'b1; xa_mode = 5'd0; xa_addr = 4'd3; xa_wdata = 32'h33;
    sw_req = 1'b1; sw_mode = 5'd16;
    @(negedge clk);
    wr_en = 1'b0; xa_we = 1'b0; sw_req = 1'b0;
    do_rd(4'd2, '0, "R11 port write dropped");
    do_rd(4'd3, '0, "R11 cross write dropped");

    // R11: write port wins over cross port on the same live register
    wr_en = 1'b1; wr_addr = 4'd4; wr_data = 32'h44;
    xa_we = 1'b1; xa_mode = 5'd0; xa_addr = 4'd4; xa_wdata = 32'h99;
    @(negedge clk);
    wr_en = 1'b0; xa_we = 1'b0;
    do_rd(4'd4, 32'h44, "R11 priority");

    // R2: no forwarding, and independent ports
    do_wr(4'd5, 32'h55);
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h66;
    rd_a_addr = 4'd5; rd_b_addr = 4'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 old value", rd_a_data, 32'h55);
    check("R2 port b", rd_b_data, 32'hA0);
    do_rd(4'd5, 32'h66, "R2 new value");

    // R12 and R4: undefined bank fresh copy visible next cycle
    do_sw(5'd27);
    check("R12 mode", 32'(cur_mode), 32'd27);
    do_rd(4'd13, '0, "R4 undefined bank");

    // R1: reset clears everything again
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 mode after run", 32'(cur_mode), 32'd19);
    do_rd(4'd0, '0, "R1 r0 cleared");
    do_xr(5'd17, 4'd8, '0, "R1 fast copy cleared");

    done = 1;
    report();
  end
endmodule